// File: doc/BRIEF.md
# Crystal Oscillator Autostart and Clock-Source Select Controller

This block decides when the high-frequency crystal oscillator runs and when it drives the high-frequency clock. It looks at the power mode, whether the radio controller is awake, whether the oscillator reports ready, and three configuration bits. These bits are the active-mode autostart, the active-mode autoselect and the radio ready-select. From them it forms two hardware reasons, an enable reason and a select reason. While a reason holds, software cannot turn the oscillator off or move the clock to another source.

Software drives the block through four strobes: enable, disable, a clock-source write and an error-clear. A refused disable or deselect raises a sticky error flag. A write of the reserved source code raises a separate general error flag. Entry into a deep-sleep mode is the only way hardware turns the oscillator off. The block never deselects the oscillator on its own.

Power modes 0 and 1 are the active modes and modes 2, 3 and 4 are deep sleep. The clock-source code is 0 for the internal RC oscillator, 1 for the crystal oscillator, 2 for the low-frequency source and 3 reserved. All outputs are registered and update on the rising edge after the inputs that cause them. Reset is synchronous and active-high.

Top module: `osc_autostart_ctl`

## Requirements
- R1: While reset is high, at the next clock edge osc_en goes to 0, clk_sel to 0 (RC), and dis_err, gen_err and hw_req_status to 0.
- R2: An enable reason holds when the power mode is 0 or 1 and either the active autostart bit or the active autoselect bit is 1, or when the radio is awake and the radio ready-select bit is 1. osc_en is 1 one cycle after an enable reason, unless R9 applies.
- R3: A select reason holds when the mode is 0 or 1 and the active autoselect bit is 1, or when the radio is awake, the oscillator is ready and the radio ready-select bit is 1. clk_sel becomes 1 one cycle later. In the active case this happens even when osc_ready is 0.
- R4: With the active autoselect bit at 0, a radio-driven select waits for osc_ready. Until then, software clock-source writes take effect.
- R5: A disable strobe during an enable reason is ignored (osc_en stays 1) and sets dis_err.
- R6: A clock-source write of any code other than 1 during a select reason is ignored and sets dis_err.
- R7: A refused disable or deselect never sets gen_err. A write of code 3 outside a select reason is ignored and sets gen_err.
- R8: With no enable or select reason, the disable and enable strobes and writes of codes 0 to 2 take effect one cycle later without setting any error flag.
- R9: In the first cycle the mode is 2 to 4 after being 0 or 1, osc_en is cleared, overriding every other enable cause.
- R10: The error-clear strobe clears both flags. An error raised in the same cycle wins over the clear.
- R11: hw_req_status equals radio_awake one cycle earlier. On its own it neither enables nor selects the oscillator.
- R12: The block never deselects the oscillator. After the select reasons go away, clk_sel holds until software writes a new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 3 | Power mode: 0–1 active, 2–4 deep sleep |
| radio_awake | input | 1 | Radio controller awake |
| osc_ready | input | 1 | Oscillator reports ready |
| cfg_auto_start | input | 1 | Active-mode autostart enable bit |
| cfg_auto_sel | input | 1 | Active-mode autoselect bit |
| cfg_radio_rdysel | input | 1 | Radio ready-select bit |
| sw_enable | input | 1 | Software enable strobe |
| sw_disable | input | 1 | Software disable strobe |
| sw_sel_wr | input | 1 | Software clock-source write strobe |
| sw_sel_val | input | 2 | Requested clock-source code |
| err_clr | input | 1 | Write-one-to-clear strobe for both error flags |
| osc_en | output | 1 | Oscillator enable |
| clk_sel | output | 2 | Current clock-source code |
| dis_err | output | 1 | Sticky refused disable/deselect flag |
| gen_err | output | 1 | Sticky general error flag |
| hw_req_status | output | 1 | Radio hardware-request status |

## Verification
Every output of this block sits one register stage behind the inputs that drive it: enable, selection, both error flags and the request status. The only extra state is the previous-mode register that detects deep-sleep entry, and it adds no further delay. The bench therefore drives each stimulus row at a falling edge and compares all five outputs at the next falling edge, with exactly one rising edge in between. The deep-sleep entry rows depend on the mode of the row before, so the rows are ordered to pair an active row with a deep one where that matters.

// File: rtl/osc_autostart_pkg.sv
package osc_autostart_pkg;

    localparam int MODE_W   = 3;
    localparam int SEL_W    = 2;
    localparam int DEEP_MIN = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RC  = 2'd0,
        SRC_XO  = 2'd1,
        SRC_LF  = 2'd2,
        SRC_RSV = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic auto_en;
        logic auto_sel;
    } reasons_t;

    function automatic logic is_deep(input logic [MODE_W-1:0] mode);
        return mode >= MODE_W'(DEEP_MIN);
    endfunction

endpackage

// File: rtl/osc_reason_dec.sv
module osc_reason_dec
    import osc_autostart_pkg::*;
(
    input  logic [MODE_W-1:0] pwr_mode,
    input  logic              radio_awake,
    input  logic              osc_ready,
    input  logic              cfg_auto_start,
    input  logic              cfg_auto_sel,
    input  logic              cfg_radio_rdysel,
    output reasons_t          reasons
);

    logic active_mode;
    logic radio_want;

    always_comb begin
        active_mode      = !is_deep(pwr_mode);
        radio_want       = radio_awake && cfg_radio_rdysel;
        reasons.auto_en  = (active_mode && (cfg_auto_start || cfg_auto_sel)) || radio_want;
        reasons.auto_sel = (active_mode && cfg_auto_sel) || (radio_want && osc_ready);
    end

endmodule

// File: rtl/osc_en_ctl.sv
module osc_en_ctl
    import osc_autostart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] pwr_mode,
    input  reasons_t          reasons,
    input  logic              sw_enable,
    input  logic              sw_disable,
    output logic              osc_en
);

    logic prev_deep_q;
    logic en_q;
    logic deep_entry;

    always_comb begin
        deep_entry = is_deep(pwr_mode) && !prev_deep_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_deep_q <= 1'b0;
            en_q        <= 1'b0;
        end else begin
            prev_deep_q <= is_deep(pwr_mode);
            if (deep_entry)
                en_q <= 1'b0;
            else if (reasons.auto_en)
                en_q <= 1'b1;
            else if (sw_disable)
                en_q <= 1'b0;
            else if (sw_enable)
                en_q <= 1'b1;
        end
    end

    assign osc_en = en_q;

endmodule

// File: rtl/osc_sel_ctl.sv
module osc_sel_ctl
    import osc_autostart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reasons_t         reasons,
    input  logic             sw_sel_wr,
    input  logic [SEL_W-1:0] sw_sel_val,
    output logic [SEL_W-1:0] clk_sel
);

    clk_src_e sel_q;
    logic     wr_legal;

    always_comb begin
        wr_legal = sw_sel_wr && (sw_sel_val != SRC_RSV);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SRC_RC;
        else if (reasons.auto_sel)
            sel_q <= SRC_XO;
        else if (wr_legal)
            sel_q <= clk_src_e'(sw_sel_val);
    end

    assign clk_sel = sel_q;

endmodule

// File: rtl/osc_err_flags.sv
module osc_err_flags
    import osc_autostart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reasons_t         reasons,
    input  logic             sw_disable,
    input  logic             sw_sel_wr,
    input  logic [SEL_W-1:0] sw_sel_val,
    input  logic             err_clr,
    output logic             dis_err,
    output logic             gen_err
);

    logic refuse_dis;
    logic refuse_desel;
    logic bad_code;
    logic dis_err_q;
    logic gen_err_q;

    always_comb begin
        refuse_dis   = reasons.auto_en && sw_disable;
        refuse_desel = reasons.auto_sel && sw_sel_wr && (sw_sel_val != SRC_XO);
        bad_code     = !reasons.auto_sel && sw_sel_wr && (sw_sel_val == SRC_RSV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_err_q <= 1'b0;
            gen_err_q <= 1'b0;
        end else begin
            if (refuse_dis || refuse_desel)
                dis_err_q <= 1'b1;
            else if (err_clr)
                dis_err_q <= 1'b0;
            if (bad_code)
                gen_err_q <= 1'b1;
            else if (err_clr)
                gen_err_q <= 1'b0;
        end
    end

    assign dis_err = dis_err_q;
    assign gen_err = gen_err_q;

endmodule

// File: rtl/osc_autostart_ctl.sv
module osc_autostart_ctl
    import osc_autostart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] pwr_mode,
    input  logic              radio_awake,
    input  logic              osc_ready,
    input  logic              cfg_auto_start,
    input  logic              cfg_auto_sel,
    input  logic              cfg_radio_rdysel,
    input  logic              sw_enable,
    input  logic              sw_disable,
    input  logic              sw_sel_wr,
    input  logic [SEL_W-1:0]  sw_sel_val,
    input  logic              err_clr,
    output logic              osc_en,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              dis_err,
    output logic              gen_err,
    output logic              hw_req_status
);

    reasons_t reasons;
    logic     req_q;

    osc_reason_dec u_dec (
        .pwr_mode         (pwr_mode),
        .radio_awake      (radio_awake),
        .osc_ready        (osc_ready),
        .cfg_auto_start   (cfg_auto_start),
        .cfg_auto_sel     (cfg_auto_sel),
        .cfg_radio_rdysel (cfg_radio_rdysel),
        .reasons          (reasons)
    );

    osc_en_ctl u_en (
        .clk        (clk),
        .rst        (rst),
        .pwr_mode   (pwr_mode),
        .reasons    (reasons),
        .sw_enable  (sw_enable),
        .sw_disable (sw_disable),
        .osc_en     (osc_en)
    );

    osc_sel_ctl u_sel (
        .clk        (clk),
        .rst        (rst),
        .reasons    (reasons),
        .sw_sel_wr  (sw_sel_wr),
        .sw_sel_val (sw_sel_val),
        .clk_sel    (clk_sel)
    );

    osc_err_flags u_err (
        .clk        (clk),
        .rst        (rst),
        .reasons    (reasons),
        .sw_disable (sw_disable),
        .sw_sel_wr  (sw_sel_wr),
        .sw_sel_val (sw_sel_val),
        .err_clr    (err_clr),
        .dis_err    (dis_err),
        .gen_err    (gen_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= radio_awake;
    end

    assign hw_req_status = req_q;

endmodule

// File: rtl/osc_autostart_chk.sv
module osc_autostart_chk
    import osc_autostart_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] pwr_mode,
    input logic              radio_awake,
    input logic              osc_ready,
    input logic              cfg_auto_start,
    input logic              cfg_auto_sel,
    input logic              cfg_radio_rdysel,
    input logic              sw_enable,
    input logic              sw_disable,
    input logic              sw_sel_wr,
    input logic [SEL_W-1:0]  sw_sel_val,
    input logic              err_clr,
    input logic              osc_en,
    input logic [SEL_W-1:0]  clk_sel,
    input logic              dis_err,
    input logic              gen_err,
    input logic              hw_req_status
);

    logic act;
    logic want_en;
    logic want_sel;

    assign act      = pwr_mode < MODE_W'(DEEP_MIN);
    assign want_en  = (act && (cfg_auto_start || cfg_auto_sel)) || (radio_awake && cfg_radio_rdysel);
    assign want_sel = (act && cfg_auto_sel) || (radio_awake && cfg_radio_rdysel && osc_ready);

    // R2
    auto_en_chk: assert property (@(posedge clk) disable iff (rst)
        (want_en && !$past(rst) && (act || $past(pwr_mode) >= MODE_W'(DEEP_MIN))) |=> osc_en);

    // R3
    act_sel_now_chk: assert property (@(posedge clk) disable iff (rst)
        (act && cfg_auto_sel) |=> (clk_sel == 2'd1));

    // R5
    refused_dis_chk: assert property (@(posedge clk) disable iff (rst)
        (want_en && sw_disable) |=> dis_err);

    // R6
    refused_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (want_sel && sw_sel_wr && sw_sel_val != 2'd1) |=> (dis_err && clk_sel == 2'd1));

    // R7
    gen_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!gen_err && !(sw_sel_wr && sw_sel_val == 2'd3)) |=> !gen_err);

    // R9
    deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pwr_mode >= MODE_W'(DEEP_MIN) && $past(pwr_mode) < MODE_W'(DEEP_MIN)) |=> !osc_en);

    // R11
    req_follow_chk: assert property (@(posedge clk) disable iff (rst)
        radio_awake |=> hw_req_status);

    // R12
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!want_sel && !sw_sel_wr) |=> $stable(clk_sel));

endmodule

bind osc_autostart_ctl osc_autostart_chk i_chk (
    .clk              (clk),
    .rst              (rst),
    .pwr_mode         (pwr_mode),
    .radio_awake      (radio_awake),
    .osc_ready        (osc_ready),
    .cfg_auto_start   (cfg_auto_start),
    .cfg_auto_sel     (cfg_auto_sel),
    .cfg_radio_rdysel (cfg_radio_rdysel),
    .sw_enable        (sw_enable),
    .sw_disable       (sw_disable),
    .sw_sel_wr        (sw_sel_wr),
    .sw_sel_val       (sw_sel_val),
    .err_clr          (err_clr),
    .osc_en           (osc_en),
    .clk_sel          (clk_sel),
    .dis_err          (dis_err),
    .gen_err          (gen_err),
    .hw_req_status    (hw_req_status)
);

// File: tb/test_osc_autostart_ctl.sv
`timescale 1ns/1ps
module test_osc_autostart_ctl;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] pwr_mode;
    logic       radio_awake, osc_ready, cfg_auto_start, cfg_auto_sel, cfg_radio_rdysel;
    logic       sw_enable, sw_disable, sw_sel_wr, err_clr;
    logic [1:0] sw_sel_val;
    logic       osc_en, dis_err, gen_err, hw_req_status;
    logic [1:0] clk_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    osc_autostart_ctl i_osc_autostart_ctl (
        .clk(clk), .rst(rst), .pwr_mode(pwr_mode), .radio_awake(radio_awake),
        .osc_ready(osc_ready), .cfg_auto_start(cfg_auto_start), .cfg_auto_sel(cfg_auto_sel),
        .cfg_radio_rdysel(cfg_radio_rdysel), .sw_enable(sw_enable), .sw_disable(sw_disable),
        .sw_sel_wr(sw_sel_wr), .sw_sel_val(sw_sel_val), .err_clr(err_clr),
        .osc_en(osc_en), .clk_sel(clk_sel), .dis_err(dis_err), .gen_err(gen_err),
        .hw_req_status(hw_req_status)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] mode;
        logic       awk, rdy, ast, asl, rsl, dis, ena, wr;
        logic [1:0] val;
        logic       clr;
        logic       e_en;
        logic [1:0] e_sel;
        logic       e_de, e_ge, e_rq;
    } vec_t;

    localparam int NV = 24;
    //                    req  mode awk rdy ast asl rsl dis ena wr val clr | en sel de ge rq
    localparam vec_t VECS [NV] = '{
        '{4'd8, 3'd0, 0,0,0,0,0, 0,0,0, 2'd0, 0,  0,2'd0,0,0,0}, // R8 idle
        '{4'd8, 3'd0, 0,0,0,0,0, 0,1,0, 2'd0, 0,  1,2'd0,0,0,0}, // R8 sw enable
        '{4'd8, 3'd0, 0,0,0,0,0, 0,0,1, 2'd2, 0,  1,2'd2,0,0,0}, // R8 select LF
        '{4'd8, 3'd0, 0,0,0,0,0, 1,0,0, 2'd0, 0,  0,2'd2,0,0,0}, // R8 sw disable
        '{4'd8, 3'd0, 0,0,0,0,0, 0,0,1, 2'd0, 0,  0,2'd0,0,0,0}, // R8 select RC
        '{4'd2, 3'd0, 0,0,1,0,0, 0,0,0, 2'd0, 0,  1,2'd0,0,0,0}, // R2 active autostart
        '{4'd5, 3'd0, 0,0,1,0,0, 1,0,0, 2'd0, 0,  1,2'd0,1,0,0}, // R5 refused disable
        '{4'd10,3'd0, 0,0,1,0,0, 0,0,0, 2'd0, 1,  1,2'd0,0,0,0}, // R10 clear
        '{4'd3, 3'd0, 0,0,0,1,0, 0,0,0, 2'd0, 0,  1,2'd1,0,0,0}, // R3 immediate select, not ready
        '{4'd6, 3'd0, 0,0,0,1,0, 0,0,1, 2'd0, 0,  1,2'd1,1,0,0}, // R6 refused deselect
        '{4'd10,3'd0, 0,0,0,1,0, 0,0,1, 2'd3, 1,  1,2'd1,1,0,0}, // R10 set beats clear, R7 no gen_err
        '{4'd12,3'd0, 0,0,0,0,0, 0,0,0, 2'd0, 1,  1,2'd1,0,0,0}, // R12 holds select
        '{4'd7, 3'd0, 0,0,0,0,0, 0,0,1, 2'd3, 0,  1,2'd1,0,1,0}, // R7 reserved code
        '{4'd10,3'd0, 0,0,0,0,0, 0,0,0, 2'd0, 1,  1,2'd1,0,0,0}, // R10 clears gen_err
        '{4'd9, 3'd2, 0,0,0,0,0, 0,0,0, 2'd0, 0,  0,2'd1,0,0,0}, // R9 deep entry
        '{4'd4, 3'd2, 1,0,0,0,1, 0,0,1, 2'd0, 0,  1,2'd0,0,0,1}, // R4 sw select while not ready
        '{4'd4, 3'd2, 1,0,0,0,1, 0,0,1, 2'd2, 0,  1,2'd2,0,0,1}, // R4 another sw select
        '{4'd4, 3'd2, 1,1,0,0,1, 0,0,0, 2'd0, 0,  1,2'd1,0,0,1}, // R4 select on ready
        '{4'd11,3'd2, 1,1,0,0,0, 0,0,0, 2'd0, 0,  1,2'd1,0,0,1}, // R11 request only
        '{4'd11,3'd2, 1,1,0,0,0, 1,0,0, 2'd0, 0,  0,2'd1,0,0,1}, // R11 free disable
        '{4'd11,3'd3, 1,0,0,0,0, 0,0,0, 2'd0, 0,  0,2'd1,0,0,1}, // R11 no enable
        '{4'd2, 3'd1, 1,0,0,0,1, 0,0,0, 2'd0, 0,  1,2'd1,0,0,1}, // R2 radio enable
        '{4'd9, 3'd4, 1,1,0,0,1, 0,0,0, 2'd0, 0,  0,2'd1,0,0,1}, // R9 entry beats radio
        '{4'd2, 3'd4, 1,1,0,0,1, 0,0,0, 2'd0, 0,  1,2'd1,0,0,1}  // R2 radio re-enable
    };

    task automatic idle_inputs();
        pwr_mode = 3'd0; radio_awake = 0; osc_ready = 0; cfg_auto_start = 0;
        cfg_auto_sel = 0; cfg_radio_rdysel = 0; sw_enable = 0; sw_disable = 0;
        sw_sel_wr = 0; sw_sel_val = 2'd0; err_clr = 0;
    endtask

    task automatic check_all(input string tag, input logic e_en, input logic [1:0] e_sel,
                             input logic e_de, input logic e_ge, input logic e_rq);
        checks++;
        if ({osc_en, clk_sel, dis_err, gen_err, hw_req_status} !== {e_en, e_sel, e_de, e_ge, e_rq}) begin
            errors++;
            $display("FAIL %s: en/sel/de/ge/rq actual %b/%0d/%b/%b/%b expected %b/%0d/%b/%b/%b",
                     tag, osc_en, clk_sel, dis_err, gen_err, hw_req_status,
                     e_en, e_sel, e_de, e_ge, e_rq);
        end
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        check_all("R1 reset defaults", 0, 2'd0, 0, 0, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pwr_mode = VECS[i].mode; radio_awake = VECS[i].awk; osc_ready = VECS[i].rdy;
            cfg_auto_start = VECS[i].ast; cfg_auto_sel = VECS[i].asl;
            cfg_radio_rdysel = VECS[i].rsl; sw_disable = VECS[i].dis; sw_enable = VECS[i].ena;
            sw_sel_wr = VECS[i].wr; sw_sel_val = VECS[i].val; err_clr = VECS[i].clr;
            @(negedge clk);
            check_all($sformatf("R%0d row %0d", VECS[i].req, i),
                      VECS[i].e_en, VECS[i].e_sel, VECS[i].e_de, VECS[i].e_ge, VECS[i].e_rq);
        end

        // R1: reset from a busy state
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        check_all("R1 mid-run reset", 0, 2'd0, 0, 0, 0);
        rst = 1'b0;

        // R3: active autoselect straight after reset, oscillator not ready
        cfg_auto_sel = 1'b1;
        @(negedge clk);
        check_all("R3 select before ready", 1, 2'd1, 0, 0, 0);

        // R6/R7: reserved write under select reason is a deselect refusal only
        sw_sel_wr = 1'b1; sw_sel_val = 2'd3;
        @(negedge clk);
        check_all("R6 reserved under select", 1, 2'd1, 1, 0, 0);

        // R5/R12: both strobes refused while reasons hold, then reasons drop
        sw_sel_wr = 1'b0; sw_disable = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        check_all("R5 disable refused", 1, 2'd1, 1, 0, 0);
        idle_inputs();
        @(negedge clk);
        check_all("R12 selection kept", 1, 2'd1, 1, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule